// File: doc/BRIEF.md
# DRAM Wake-up and Refresh Sequencer

This block owns the row, column, write-enable and output-enable strobes of an asynchronous page-mode DRAM array during the array's start-up and refresh cycles. After reset it keeps every strobe inactive for a parameterized settling pause. It then runs a burst of eight wake-up refresh cycles and raises `rdy`. A mode input picks the refresh style, either column-before-row or row-only. In row-only style the block also supplies an incrementing refresh row address.

Once ready, an interval counter raises a refresh request once per retention period divided by the row count. An access port asks for the array with `acc_req` and holds it while `acc_gnt` is high. A running access is never cut short; a pending refresh waits for `acc_req` to drop. If a write access ends while a refresh is pending, the refresh follows at once as a hidden refresh, with write-enable held low and output-enable held high.

A watchdog measures the time since the last completed refresh. When that time reaches the full retention period, the block raises `ovd` and drops `rdy`. It then replays the whole eight-cycle wake-up burst before it grants the array again.

Top module: `dram_wake_refresh`

## Requirements
- R1: After reset release, `ras_n`, `cas_n`, `we_n` and `oe_n` stay high and `acc_gnt` stays low for at least `PAUSE_CYC` clock cycles.
- R2: After the pause, exactly eight refresh cycles (eight falling edges of `ras_n`) occur before `rdy` rises. `acc_gnt` is never high while `rdy` has not yet risen.
- R3: With `cbr_mode`=1, a refresh drives `cas_n` low exactly `TCSR_CYC` cycles before `ras_n` falls, holds it low while `ras_n` is low, and keeps `row_oe` low.
- R4: With `cbr_mode`=0, a refresh keeps `cas_n` high and drives `row_oe` high while `ras_n` is low. `ref_row` at each falling edge of `ras_n` is the previous value plus one, modulo `ROWS`.
- R5: Each refresh holds `ras_n` low for exactly `TRAS_CYC` cycles. `ras_n` stays high for at least `TRP_CYC` cycles before it falls.
- R6: Once ready and idle, refreshes occur at one per `REF_CYC/ROWS` cycles.
- R7: While `acc_gnt` is high, `ras_n` and `cas_n` stay high. `acc_gnt` stays high until `acc_req` drops, and it rises within a bounded number of cycles of a request.
- R8: When `acc_req` drops with `acc_wr`=1 while a periodic refresh is pending, the next refresh keeps `we_n` low from its start through the low phase of `ras_n`. In every other refresh, `we_n` stays high. `oe_n` is always high.
- R9: If no refresh completes within `REF_CYC` cycles, `ovd` rises and `rdy` falls on the same edge. After the access ends, exactly eight refreshes run, and then `rdy` rises and `ovd` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cbr_mode | input | 1 | 1 = column-before-row refresh, 0 = row-only refresh |
| acc_req | input | 1 | Access port requests the array; held for the whole access |
| acc_wr | input | 1 | Current access is a write; sampled when acc_req drops |
| acc_gnt | output | 1 | Array granted to the access port |
| rdy | output | 1 | Wake-up sequence complete and array usable |
| ovd | output | 1 | Refresh overdue; wake-up replay pending or running |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low (held high) |
| row_oe | output | 1 | Drive ref_row onto the address bus |
| ref_row | output | $clog2(ROWS) | Row address for row-only refresh |

## Verification
A periodic refresh request can fall in the same cycle as the end of an access. This is provoked by holding a write access past one refresh interval, so the request waits, and then releasing it. The check is that the refresh that follows starts without a gap and keeps write-enable low. The refresh-overdue watchdog can also expire while an access still holds the grant. This is provoked by holding a request longer than the retention period. The check is that `rdy` drops on the same edge as `ovd`, that the grant is held until release, and that exactly eight refreshes run before `rdy` returns.

// File: rtl/dram_wake_refresh_pkg.sv
package dram_wake_refresh_pkg;
    typedef enum logic [2:0] {
        ST_PAUSE  = 3'd0,
        ST_IDLE   = 3'd1,
        ST_ACCESS = 3'd2,
        ST_PRE    = 3'd3,
        ST_CSR    = 3'd4,
        ST_ACT    = 3'd5,
        ST_REC    = 3'd6
    } seq_state_e;
endpackage

// File: rtl/dram_wake_refresh.sv
module dram_wake_refresh
    import dram_wake_refresh_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int PAUSE_CYC = CLK_MHZ * 100,
    parameter int TRP_CYC   = (CLK_MHZ * 40 + 999) / 1000,
    parameter int TRAS_CYC  = (CLK_MHZ * 60 + 999) / 1000,
    parameter int TCSR_CYC  = (CLK_MHZ * 10 + 999) / 1000,
    parameter int REF_CYC   = CLK_MHZ * 64000,
    parameter int ROWS      = 4096,
    parameter int WAKE_N    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cbr_mode,
    input  logic                    acc_req,
    input  logic                    acc_wr,
    output logic                    acc_gnt,
    output logic                    rdy,
    output logic                    ovd,
    output logic                    ras_n,
    output logic                    cas_n,
    output logic                    we_n,
    output logic                    oe_n,
    output logic                    row_oe,
    output logic [$clog2(ROWS)-1:0] ref_row
);
    localparam int RW    = $clog2(ROWS);
    localparam int INT_C = REF_CYC / ROWS;
    localparam int M1    = (PAUSE_CYC > TRAS_CYC) ? PAUSE_CYC : TRAS_CYC;
    localparam int M2    = (TRP_CYC > TCSR_CYC) ? TRP_CYC : TCSR_CYC;
    localparam int MAXT  = (M1 > M2) ? M1 : M2;
    localparam int TW    = $clog2(MAXT + 1);
    localparam int WDW   = $clog2(REF_CYC + 1);
    localparam int IW    = $clog2(INT_C + 1);
    localparam int KW    = $clog2(WAKE_N + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [TW-1:0]  tmr;
        logic [WDW-1:0] wd;
        logic [IW-1:0]  ivl;
        logic [KW-1:0]  wake;
        logic           pend;
        logic           ready;
        logic           overdue;
        logic           cbr;
        logic           hid;
        logic [RW-1:0]  row;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (q.st != ST_PAUSE && q.wd < WDW'(REF_CYC - 1))
            d.wd = q.wd + 1'b1;
        case (q.st)
            ST_PAUSE: begin
                if (q.tmr == '0) begin
                    d.st   = ST_IDLE;
                    d.wake = KW'(WAKE_N);
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ST_IDLE: begin
                if (q.wake != '0 || q.pend) begin
                    d.st  = ST_PRE;
                    d.tmr = TW'(TRP_CYC - 1);
                    d.cbr = cbr_mode;
                end else if (acc_req && q.ready) begin
                    d.st = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (!acc_req) begin
                    if (q.wake != '0 || q.pend) begin
                        d.st  = ST_PRE;
                        d.tmr = TW'(TRP_CYC - 1);
                        d.cbr = cbr_mode;
                        d.hid = acc_wr && (q.wake == '0);
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_PRE: begin
                if (q.tmr == '0) begin
                    d.st  = q.cbr ? ST_CSR : ST_ACT;
                    d.tmr = q.cbr ? TW'(TCSR_CYC - 1) : TW'(TRAS_CYC - 1);
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ST_CSR: begin
                if (q.tmr == '0) begin
                    d.st  = ST_ACT;
                    d.tmr = TW'(TRAS_CYC - 1);
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ST_ACT: begin
                if (q.tmr == '0) begin
                    d.st   = ST_REC;
                    d.tmr  = TW'(TRP_CYC - 1);
                    d.wd   = '0;
                    d.row  = q.row + 1'b1;
                    d.hid  = 1'b0;
                    d.pend = 1'b0;
                    if (q.wake != '0) begin
                        d.wake = q.wake - 1'b1;
                        if (q.wake == KW'(1)) begin
                            d.ready   = 1'b1;
                            d.overdue = 1'b0;
                        end
                    end
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ST_REC: begin
                if (q.tmr == '0) d.st = ST_IDLE;
                else             d.tmr = q.tmr - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
        // distributed refresh request
        if (q.st != ST_PAUSE) begin
            if (q.ivl == IW'(INT_C - 1)) begin
                d.ivl = '0;
                if (q.wake == '0) d.pend = 1'b1;
            end else begin
                d.ivl = q.ivl + 1'b1;
            end
        end
        // retention watchdog: replay the wake-up burst
        if (q.st != ST_PAUSE && !q.overdue && q.wd == WDW'(REF_CYC - 1)) begin
            d.overdue = 1'b1;
            d.ready   = 1'b0;
            d.wake    = KW'(WAKE_N);
            d.pend    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_PAUSE;
            q.tmr   <= TW'(PAUSE_CYC - 1);
        end else begin
            q <= d;
        end
    end

    assign acc_gnt = (q.st == ST_ACCESS);
    assign rdy     = q.ready;
    assign ovd     = q.overdue;
    assign ras_n   = (q.st != ST_ACT);
    assign cas_n   = !(q.cbr && (q.st == ST_CSR || q.st == ST_ACT));
    assign we_n    = !(q.hid && (q.st == ST_PRE || q.st == ST_CSR || q.st == ST_ACT));
    assign oe_n    = 1'b1;
    assign row_oe  = (q.st == ST_ACT) && !q.cbr;
    assign ref_row = q.row;

    // R2: the array is only granted once the wake-up burst is done
    a_r2_grant_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_gnt) |-> $past(rdy));
    // R3: row strobe never falls without the column strobe already low in cbr style
    a_r3_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !row_oe) |-> $past(!cas_n));
    // R7: no refresh strobe while the access port owns the array
    a_r7_quiet_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> (ras_n && cas_n));
    // R7: grant is held while the request stays high
    a_r7_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_gnt && acc_req) |=> acc_gnt);
    // R9: overdue and loss of ready happen together
    a_r9_ovd_drops_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovd) |-> (!rdy && $past(rdy)));
    // R8: output enable never asserted
    a_r8_oe_high: assert property (@(posedge clk) disable iff (!rst_n) oe_n);
endmodule

// File: tb/sim_dram_wake_refresh.sv
module sim_dram_wake_refresh;
    localparam int PAUSE = 20, TRP = 2, TRAS = 3, TCSR = 1, REFC = 200, ROWS = 4;
    localparam int INTV = REFC / ROWS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cbr_mode = 1'b1, acc_req = 1'b0, acc_wr = 1'b0;
    logic acc_gnt, rdy, ovd, ras_n, cas_n, we_n, oe_n, row_oe;
    logic [1:0] ref_row;

    always #2.5 clk = ~clk;

    dram_wake_refresh #(.CLK_MHZ(200), .PAUSE_CYC(PAUSE), .TRP_CYC(TRP), .TRAS_CYC(TRAS),
        .TCSR_CYC(TCSR), .REF_CYC(REFC), .ROWS(ROWS), .WAKE_N(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_gnt(acc_gnt), .rdy(rdy), .ovd(ovd), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .row_oe(row_oe), .ref_row(ref_row));

    int vec = 0, bad = 0;
    int cyc = 0, falls = 0, hi_run = 0, lo_run = 0, cas_run = 0;
    int first_low = -1;
    logic prev_ras = 1'b1, seen_rdy = 1'b0, expect_hid = 1'b0, row_valid = 1'b0;
    logic [1:0] last_row = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // edge monitor, sampled on the falling clock edge
    always @(negedge clk) if (rst_n) begin
        cyc++;
        if (first_low < 0 && (!ras_n || !cas_n || !we_n || acc_gnt)) first_low = cyc;
        if (rdy) seen_rdy = 1'b1;
        if (acc_gnt && !seen_rdy) chk(0, "R2 grant before ready", 1, 0);
        if (acc_gnt && (!ras_n || !cas_n)) chk(0, "R7 strobe during grant", 0, 1);
        if (!oe_n) chk(0, "R8 oe_n", oe_n, 1);
        if (prev_ras && !ras_n) begin
            falls++;
            chk(hi_run >= TRP, "R5 precharge", hi_run, TRP);
            if (cas_run > 0) begin
                chk(cas_run == TCSR && !row_oe, "R3 cas lead", cas_run, TCSR);
                row_valid = 1'b0;
            end else begin
                chk(row_oe, "R4 row_oe", row_oe, 1);
                if (row_valid) chk(ref_row == last_row + 2'd1, "R4 row step", ref_row, last_row + 2'd1);
                last_row = ref_row; row_valid = 1'b1;
            end
            chk(we_n == !expect_hid, "R8 we_n", we_n, !expect_hid);
            expect_hid = 1'b0;
        end
        if (!prev_ras && ras_n) chk(lo_run == TRAS, "R5 ras width", lo_run, TRAS);
        if (!ras_n && !cbr_mode_at_fall_ok()) ;
        lo_run  = ras_n ? 0 : lo_run + 1;
        hi_run  = ras_n ? ((acc_gnt) ? 0 : hi_run + 1) : 0;
        cas_run = (cas_n || !ras_n) ? (cas_n ? 0 : cas_run) : cas_run + 1;
        prev_ras = ras_n;
    end

    function automatic bit cbr_mode_at_fall_ok();
        return 1'b1;
    endfunction

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    int f0, wait_n;
    initial begin
        acc_req = 1'b1;
        wait_cyc(3);
        rst_n = 1'b1;
        // R1 reset state and pause
        @(negedge clk);
        chk(ras_n && cas_n && we_n && oe_n && !acc_gnt && !rdy, "R1 reset state", ras_n, 1);
        wait_n = 0;
        while (!rdy && wait_n < 500) begin @(negedge clk); wait_n++; end
        chk(first_low > PAUSE, "R1 pause length", first_low, PAUSE + 1);
        chk(falls == 8, "R2 wake-up count", falls, 8);
        acc_req = 1'b0;
        wait_cyc(8);
        // R6 periodic refresh, cbr style
        f0 = falls;
        wait_cyc(4 * INTV);
        chk(falls - f0 >= 3 && falls - f0 <= 5, "R6 refresh rate", falls - f0, 4);
        // R4 row-only style
        cbr_mode = 1'b0;
        f0 = falls;
        wait_cyc(4 * INTV);
        chk(falls - f0 >= 3 && falls - f0 <= 5, "R6 rate row-only", falls - f0, 4);
        cbr_mode = 1'b1;
        // R7 sweep of access lengths
        for (int len = 1; len <= 12; len++) begin
            acc_req = 1'b1;
            wait_n = 0;
            while (!acc_gnt && wait_n < 40) begin @(negedge clk); wait_n++; end
            chk(acc_gnt, "R7 grant latency", wait_n, TRP + TCSR + TRAS + TRP + 4);
            wait_cyc(len);
            chk(acc_gnt, "R7 grant held", acc_gnt, 1);
            acc_req = 1'b0;
            wait_cyc(len + 2);
        end
        // R8 hidden refresh after a write that outlasts one interval
        wait_n = 0;
        while (ras_n && wait_n < 100) begin @(negedge clk); wait_n++; end
        wait_cyc(TRAS + TRP + 2);
        acc_req = 1'b1; acc_wr = 1'b1;
        wait_cyc(INTV + 10);
        chk(acc_gnt && ras_n, "R7 long write held", acc_gnt, 1);
        f0 = falls;
        expect_hid = 1'b1;
        acc_req = 1'b0;
        wait_cyc(1);
        acc_wr = 1'b0;
        chk(!we_n, "R8 we low at start", we_n, 0);
        wait_cyc(TRP + TCSR + TRAS + 2);
        chk(falls == f0 + 1, "R8 hidden follows", falls - f0, 1);
        wait_cyc(10);
        // R9 overdue: hold access past the retention period
        acc_req = 1'b1;
        wait_n = 0;
        while (!ovd && wait_n < 2 * REFC) begin @(negedge clk); wait_n++; end
        chk(ovd && !rdy, "R9 overdue flag", ovd, 1);
        chk(acc_gnt, "R9 access not cut", acc_gnt, 1);
        f0 = falls;
        acc_req = 1'b0;
        wait_n = 0;
        while (!rdy && wait_n < 500) begin @(negedge clk); wait_n++; end
        chk(falls - f0 == 8, "R9 replay count", falls - f0, 8);
        chk(rdy && !ovd, "R9 ready again", ovd, 0);
        wait_cyc(20);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        vec++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule